// File: doc/BRIEF.md
# Indexed Channel Enable and Flag Register Bank

This block is the global control register bank of a multi-channel DMA engine. For every channel it holds a hardware-request enable bit, an error-interrupt enable bit, an interrupt flag, an error flag, a done flag and a start bit. Software writes a whole mask word to change the enables. It can also write one channel number into a dedicated byte register, which sets or clears that channel's bit in a single write. No read-modify-write is needed, so two software agents cannot lose each other's updates.

The channel datapath raises flags through per-channel input strobes. It consumes start bits and acknowledges them through another strobe. Software clears interrupt, error and done flags with the indexed byte registers, and it sets start bits the same way. A channel-count parameter selects one of two address layouts: a narrow one for up to 32 channels, and a wide one for 33 to 64 channels. In the wide layout each mask is split into a high word and a low word. The register bus is byte-addressed and word-wide, with byte enables. Writes take effect on the next clock edge, and read data is returned one cycle after the read request.

Top module: `chan_enable_regs`

## Requirements
- R1: After synchronous reset all enables, flags, start bits, the control word, `irq_o`, `err_irq_o` and `rd_data` are zero.
- R2: In the narrow layout (NCH<=32) the indexed byte registers are: 0x18 clear error-interrupt enable, 0x19 set error-interrupt enable, 0x1A clear request enable, 0x1B set request enable, 0x1C clear done, 0x1D set start, 0x1E clear error flag, 0x1F clear interrupt flag. The byte at address A travels on byte lane A[1:0], gated by `wr_be[A[1:0]]`. Each enabled lane of one word write acts independently, and the result is visible after the write's clock edge.
- R3: When bit 6 of an indexed byte is 1, the action applies to every channel.
- R4: Only the low clog2(NCH) bits of an indexed byte select the channel. The bits between them and bit 6, and bit 7, are ignored.
- R5: In the narrow layout the request-enable mask word is at 0x0C and the error-interrupt-enable mask word is at 0x14. Bit i maps to channel i. A write changes only the bytes whose byte enable is set. A read at address A returns that word on `rd_data` one cycle after `rd_en`.
- R6: A pulse on `int_set[i]`, `err_set[i]` or `done_set[i]` sets the matching flag. In the narrow layout the interrupt flags are read at 0x24 and the error flags at 0x2C. The status word at 0x04 holds bit 31 = any error flag set, and bits [6:0] = the lowest channel with its error flag set.
- R7: `irq_o` is the OR of all interrupt flags. `err_irq_o` is the OR of the error flags whose error-interrupt enable is set. Both change on the same edge as the flags and enables.
- R8: When a hardware set strobe and a software indexed clear hit the same flag in the same cycle, the flag ends up set. When a software set of a start bit and `start_ack` for it coincide, the start bit ends up set.
- R9: `start_o[i]` is set by the indexed set-start register and cleared by `start_ack[i]`. `done_o[i]` is set by `done_set[i]` and cleared by the indexed clear-done register.
- R10: Writes to the flag words and the status word do not change them.
- R11: In the wide layout (NCH>32) the indexed registers are 0x18 set request, 0x19 clear request, 0x1A set error-interrupt enable, 0x1B clear error-interrupt enable, 0x1C clear interrupt, 0x1D clear error, 0x1E set start, 0x1F clear done. The mask pairs (high word holds channels 63..32, low word holds 31..0) are: request 0x08/0x0C, error-interrupt enable 0x10/0x14, interrupt flags 0x20/0x24, error flags 0x28/0x2C.
- R12: The control word at 0x00 is read/write with byte enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Byte address of the write; bits [5:2] select the word |
| wr_data | input | 32 | Write data, byte lane n on bits [8n+7:8n] |
| wr_be | input | 4 | Byte enables for the write |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 6 | Byte address of the read |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en` |
| int_set | input | NCH | Per-channel interrupt flag set strobes |
| err_set | input | NCH | Per-channel error flag set strobes |
| done_set | input | NCH | Per-channel done flag set strobes |
| start_ack | input | NCH | Per-channel start acknowledge; clears the start bit |
| req_en_o | output | NCH | Hardware-request enable per channel |
| start_o | output | NCH | Start bit per channel |
| done_o | output | NCH | Done flag per channel |
| irq_o | output | 1 | OR of the interrupt flags |
| err_irq_o | output | 1 | OR of the enabled error flags |

## Verification
Two updates to the same bit can land in the same clock: a hardware strobe from the datapath and a software write through the indexed byte registers. The bench drives `int_set`, `done_set` and `start_ack` in the very cycle that the bus carries the opposing indexed write for the same channel. It then judges the outcome in two ways: by reading the flag word back over the bus, and by watching `irq_o`, `done_o` and `start_o`. The set side must prevail. A single word write that carries four indexed bytes is also used, to show that lanes landing together act independently.

// File: rtl/chan_enable_pkg.sv
package chan_enable_pkg;

  typedef enum logic [2:0] {
    ACT_SET_REQ   = 3'd0,
    ACT_CLR_REQ   = 3'd1,
    ACT_SET_EEI   = 3'd2,
    ACT_CLR_EEI   = 3'd3,
    ACT_CLR_INT   = 3'd4,
    ACT_CLR_ERR   = 3'd5,
    ACT_SET_START = 3'd6,
    ACT_CLR_DONE  = 3'd7
  } act_e;

  localparam int N_ACT = 8;

  // bank indices
  localparam int B_REQ   = 0;
  localparam int B_EEI   = 1;
  localparam int B_INT   = 2;
  localparam int B_ERR   = 3;
  localparam int B_START = 4;
  localparam int B_DONE  = 5;
  localparam int N_BANK  = 6;

  // word offsets (byte address bits [5:2])
  localparam logic [3:0] W_CTRL   = 4'h0;
  localparam logic [3:0] W_ESTAT  = 4'h1;
  localparam logic [3:0] W_REQ_HI = 4'h2;
  localparam logic [3:0] W_REQ_LO = 4'h3;
  localparam logic [3:0] W_EEI_HI = 4'h4;
  localparam logic [3:0] W_EEI_LO = 4'h5;
  localparam logic [3:0] W_INT_HI = 4'h8;
  localparam logic [3:0] W_INT_LO = 4'h9;
  localparam logic [3:0] W_ERR_HI = 4'hA;
  localparam logic [3:0] W_ERR_LO = 4'hB;

  // byte address of each indexed action for the chosen layout
  function automatic logic [5:0] act_addr(input int a, input logic wide);
    logic [5:0] r;
    if (wide) begin
      r = 6'h18 + 6'(a);
    end else begin
      case (a)
        0:       r = 6'h1B;
        1:       r = 6'h1A;
        2:       r = 6'h19;
        3:       r = 6'h18;
        4:       r = 6'h1F;
        5:       r = 6'h1E;
        6:       r = 6'h1D;
        default: r = 6'h1C;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/chan_idx_decode.sv
module chan_idx_decode
  import chan_enable_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic                        wr_en,
  input  logic [5:0]                  wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic [3:0]                  wr_be,
  output logic [N_ACT-1:0][NCH-1:0]   act_hit,
  output logic [NCH-1:0]              req_we,
  output logic [NCH-1:0]              req_wd,
  output logic [NCH-1:0]              eei_we,
  output logic [NCH-1:0]              eei_wd,
  output logic [3:0]                  ctrl_we
);

  localparam bit WIDE = (NCH > 32);
  localparam int IDXW = (NCH > 1) ? $clog2(NCH) : 1;

  function automatic logic [NCH-1:0] expand(input logic [7:0] b);
    logic [NCH-1:0] v;
    for (int i = 0; i < NCH; i++) begin
      v[i] = b[6] | (b[IDXW-1:0] == IDXW'(i));
    end
    return v;
  endfunction

  always_comb begin
    act_hit = '0;
    for (int a = 0; a < N_ACT; a++) begin
      logic [5:0] ad;
      ad = act_addr(a, WIDE);
      if (wr_en && (wr_addr[5:2] == ad[5:2]) && wr_be[ad[1:0]]) begin
        act_hit[a] = expand(wr_data[{ad[1:0], 3'b000} +: 8]);
      end
    end
  end

  // mask word writes, one generated slice per channel
  for (genvar i = 0; i < NCH; i++) begin : g_mask
    localparam int LANE = (i % 32) / 8;
    localparam logic [3:0] RW = (i >= 32) ? W_REQ_HI : W_REQ_LO;
    localparam logic [3:0] EW = (i >= 32) ? W_EEI_HI : W_EEI_LO;
    assign req_we[i] = wr_en && (wr_addr[5:2] == RW) && wr_be[LANE];
    assign eei_we[i] = wr_en && (wr_addr[5:2] == EW) && wr_be[LANE];
    assign req_wd[i] = wr_data[i % 32];
    assign eei_wd[i] = wr_data[i % 32];
  end

  assign ctrl_we = (wr_en && (wr_addr[5:2] == W_CTRL)) ? wr_be : 4'b0000;

endmodule

// File: rtl/chan_bit_bank.sv
module chan_bit_bank #(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] set_v,
  input  logic [NCH-1:0] clr_v,
  input  logic [NCH-1:0] mask_we,
  input  logic [NCH-1:0] mask_wd,
  output logic [NCH-1:0] q,
  output logic [NCH-1:0] q_nxt
);

  // set beats clear, clear beats a mask write
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      q_nxt[i] = set_v[i] | (~clr_v[i] & (mask_we[i] ? mask_wd[i] : q[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_nxt;
  end

endmodule

// File: rtl/chan_rd_mux.sv
module chan_rd_mux
  import chan_enable_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rd_en,
  input  logic [5:0]     rd_addr,
  input  logic [31:0]    ctrl,
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] eei,
  input  logic [NCH-1:0] intf,
  input  logic [NCH-1:0] errf,
  output logic [31:0]    rd_data
);

  localparam bit WIDE = (NCH > 32);

  logic [63:0] req64, eei64, int64, err64;
  logic [31:0] estat;
  logic [31:0] sel_word;

  assign req64 = 64'(req);
  assign eei64 = 64'(eei);
  assign int64 = 64'(intf);
  assign err64 = 64'(errf);

  always_comb begin
    estat = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (errf[i]) begin
        estat[6:0] = 7'(i);
        estat[31]  = 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_addr[5:2])
      W_CTRL:   sel_word = ctrl;
      W_ESTAT:  sel_word = estat;
      W_REQ_HI: sel_word = WIDE ? req64[63:32] : 32'h0;
      W_REQ_LO: sel_word = req64[31:0];
      W_EEI_HI: sel_word = WIDE ? eei64[63:32] : 32'h0;
      W_EEI_LO: sel_word = eei64[31:0];
      W_INT_HI: sel_word = WIDE ? int64[63:32] : 32'h0;
      W_INT_LO: sel_word = int64[31:0];
      W_ERR_HI: sel_word = WIDE ? err64[63:32] : 32'h0;
      W_ERR_LO: sel_word = err64[31:0];
      default:  sel_word = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel_word;
  end

endmodule

// File: rtl/chan_enable_regs.sv
module chan_enable_regs
  import chan_enable_pkg::*;
#(
  parameter int NCH = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [5:0]     wr_addr,
  input  logic [31:0]    wr_data,
  input  logic [3:0]     wr_be,
  input  logic           rd_en,
  input  logic [5:0]     rd_addr,
  output logic [31:0]    rd_data,
  input  logic [NCH-1:0] int_set,
  input  logic [NCH-1:0] err_set,
  input  logic [NCH-1:0] done_set,
  input  logic [NCH-1:0] start_ack,
  output logic [NCH-1:0] req_en_o,
  output logic [NCH-1:0] start_o,
  output logic [NCH-1:0] done_o,
  output logic           irq_o,
  output logic           err_irq_o
);

  logic [N_ACT-1:0][NCH-1:0]  act_hit;
  logic [NCH-1:0]             req_we, req_wd, eei_we, eei_wd;
  logic [3:0]                 ctrl_we;
  logic [31:0]                ctrl_q;
  logic [N_BANK-1:0][NCH-1:0] b_set, b_clr, b_we, b_wd, b_q, b_nxt;
  logic [NCH-1:0]             int_q, err_q, eei_q;

  chan_idx_decode #(.NCH(NCH)) dec_i (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .act_hit (act_hit),
    .req_we  (req_we),
    .req_wd  (req_wd),
    .eei_we  (eei_we),
    .eei_wd  (eei_wd),
    .ctrl_we (ctrl_we)
  );

  // per-bank set / clear / mask sources
  assign b_set[B_REQ]   = act_hit[ACT_SET_REQ];
  assign b_clr[B_REQ]   = act_hit[ACT_CLR_REQ];
  assign b_we[B_REQ]    = req_we;
  assign b_wd[B_REQ]    = req_wd;

  assign b_set[B_EEI]   = act_hit[ACT_SET_EEI];
  assign b_clr[B_EEI]   = act_hit[ACT_CLR_EEI];
  assign b_we[B_EEI]    = eei_we;
  assign b_wd[B_EEI]    = eei_wd;

  assign b_set[B_INT]   = int_set;
  assign b_clr[B_INT]   = act_hit[ACT_CLR_INT];
  assign b_we[B_INT]    = '0;
  assign b_wd[B_INT]    = '0;

  assign b_set[B_ERR]   = err_set;
  assign b_clr[B_ERR]   = act_hit[ACT_CLR_ERR];
  assign b_we[B_ERR]    = '0;
  assign b_wd[B_ERR]    = '0;

  assign b_set[B_START] = act_hit[ACT_SET_START];
  assign b_clr[B_START] = start_ack;
  assign b_we[B_START]  = '0;
  assign b_wd[B_START]  = '0;

  assign b_set[B_DONE]  = done_set;
  assign b_clr[B_DONE]  = act_hit[ACT_CLR_DONE];
  assign b_we[B_DONE]   = '0;
  assign b_wd[B_DONE]   = '0;

  for (genvar k = 0; k < N_BANK; k++) begin : g_bank
    chan_bit_bank #(.NCH(NCH)) bank_i (
      .clk     (clk),
      .rst     (rst),
      .set_v   (b_set[k]),
      .clr_v   (b_clr[k]),
      .mask_we (b_we[k]),
      .mask_wd (b_wd[k]),
      .q       (b_q[k]),
      .q_nxt   (b_nxt[k])
    );
  end

  assign req_en_o = b_q[B_REQ];
  assign start_o  = b_q[B_START];
  assign done_o   = b_q[B_DONE];
  assign int_q    = b_q[B_INT];
  assign err_q    = b_q[B_ERR];
  assign eei_q    = b_q[B_EEI];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else begin
      for (int l = 0; l < 4; l++) begin
        if (ctrl_we[l]) ctrl_q[l*8 +: 8] <= wr_data[l*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o     <= 1'b0;
      err_irq_o <= 1'b0;
    end else begin
      irq_o     <= |b_nxt[B_INT];
      err_irq_o <= |(b_nxt[B_ERR] & b_nxt[B_EEI]);
    end
  end

  chan_rd_mux #(.NCH(NCH)) rd_i (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .ctrl    (ctrl_q),
    .req     (b_q[B_REQ]),
    .eei     (b_q[B_EEI]),
    .intf    (b_q[B_INT]),
    .errf    (b_q[B_ERR]),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/chan_enable_regs_chk.sv
module chan_enable_regs_chk #(
  parameter int NCH = 32
) (
  input logic           clk,
  input logic           rst,
  input logic           wr_en,
  input logic [NCH-1:0] int_set,
  input logic [NCH-1:0] err_set,
  input logic [NCH-1:0] start_ack,
  input logic [NCH-1:0] start_o,
  input logic [NCH-1:0] req_en_o,
  input logic           irq_o,
  input logic           err_irq_o,
  input logic [NCH-1:0] int_q,
  input logic [NCH-1:0] err_q,
  input logic [NCH-1:0] eei_q
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (req_en_o == '0 && start_o == '0 && !irq_o && !err_irq_o));

  assert_irq_or_R7: assert property (@(posedge clk) disable iff (rst)
    irq_o == (|int_q));

  assert_err_irq_masked_R7: assert property (@(posedge clk) disable iff (rst)
    err_irq_o == (|(err_q & eei_q)));

  assert_int_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (|int_set) |=> ((int_q & $past(int_set)) == $past(int_set)));

  assert_err_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (|err_set) |=> ((err_q & $past(err_set)) == $past(err_set)));

  assert_start_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
    ((|start_ack) && !wr_en) |=> ((start_o & $past(start_ack)) == '0));

endmodule

bind chan_enable_regs chan_enable_regs_chk #(.NCH(NCH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .int_set   (int_set),
  .err_set   (err_set),
  .start_ack (start_ack),
  .start_o   (start_o),
  .req_en_o  (req_en_o),
  .irq_o     (irq_o),
  .err_irq_o (err_irq_o),
  .int_q     (int_q),
  .err_q     (err_q),
  .eei_q     (eei_q)
);

// File: tb/chan_enable_regs_tb.sv
`timescale 1ns/1ps
module chan_enable_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;           // 0: narrow instance, 1: wide instance
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        rd_en = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic [63:0] int_set = '0, err_set = '0, done_set = '0, start_ack = '0;

  logic [31:0] rd_n, rd_w;
  logic [31:0] req_n, start_n, done_n;
  logic [63:0] req_w, start_w, done_w;
  logic        irq_n, eirq_n, irq_w, eirq_w;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  chan_enable_regs #(.NCH(32)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en & ~sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_en(rd_en & ~sel), .rd_addr(rd_addr), .rd_data(rd_n),
    .int_set(int_set[31:0] & {32{~sel}}), .err_set(err_set[31:0] & {32{~sel}}),
    .done_set(done_set[31:0] & {32{~sel}}), .start_ack(start_ack[31:0] & {32{~sel}}),
    .req_en_o(req_n), .start_o(start_n), .done_o(done_n), .irq_o(irq_n), .err_irq_o(eirq_n)
  );

  chan_enable_regs #(.NCH(64)) dut_w_i (
    .clk(clk), .rst(rst), .wr_en(wr_en & sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_be(wr_be), .rd_en(rd_en & sel), .rd_addr(rd_addr), .rd_data(rd_w),
    .int_set(int_set & {64{sel}}), .err_set(err_set & {64{sel}}),
    .done_set(done_set & {64{sel}}), .start_ack(start_ack & {64{sel}}),
    .req_en_o(req_w), .start_o(start_w), .done_o(done_w), .irq_o(irq_w), .err_irq_o(eirq_w)
  );

  function automatic logic [63:0] req_now();   return sel ? req_w   : {32'h0, req_n};   endfunction
  function automatic logic [63:0] start_now(); return sel ? start_w : {32'h0, start_n}; endfunction
  function automatic logic [63:0] done_now();  return sel ? done_w  : {32'h0, done_n};  endfunction
  function automatic logic irq_now();  return sel ? irq_w  : irq_n;  endfunction
  function automatic logic eirq_now(); return sel ? eirq_w : eirq_n; endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0;
  endtask

  task automatic wrb(input logic [5:0] a, input logic [7:0] b);
    wr(a, 32'(b) << (8 * a[1:0]), 4'b0001 << a[1:0]);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = sel ? rd_w : rd_n;
  endtask

  task automatic pulse(input int kind, input logic [63:0] v);
    @(negedge clk);
    case (kind)
      0: int_set = v;
      1: err_set = v;
      2: done_set = v;
      default: start_ack = v;
    endcase
    @(negedge clk);
    int_set = '0; err_set = '0; done_set = '0; start_ack = '0;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [63:0] exp;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: reset state
    chk("R1 req", req_now(), 64'h0);
    chk("R1 irq", {63'h0, irq_now()}, 64'h0);
    rd(6'h00, d); chk("R1 ctrl", 64'(d), 64'h0);
    rd(6'h04, d); chk("R1 estat", 64'(d), 64'h0);

    // R2: narrow sweep of set then clear request
    exp = 0;
    for (int c = 0; c < 32; c++) begin
      wrb(6'h1B, 8'(c)); exp[c] = 1'b1;
      chk("R2 set req sweep", req_now(), exp);
    end
    for (int c = 0; c < 32; c++) begin
      wrb(6'h1A, 8'(c)); exp[c] = 1'b0;
      chk("R2 clr req sweep", req_now(), exp);
    end

    // R4: bit 5 and bit 7 ignored in narrow layout
    wrb(6'h1B, 8'hA3);
    chk("R4 index masked", req_now(), 64'h8);
    // R3: all channels
    wrb(6'h1B, 8'h40);
    chk("R3 set all", req_now(), 64'hFFFF_FFFF);
    wrb(6'h1A, 8'h45);
    chk("R3 clr all", req_now(), 64'h0);

    // R2: four lanes in one word write
    wr(6'h18, 32'h0506_0809, 4'hF);
    chk("R2 multi-lane req", req_now(), 64'h20);
    rd(6'h14, d); chk("R2 multi-lane eei", 64'(d), 64'h100);
    wrb(6'h18, 8'h08);
    wrb(6'h1A, 8'h05);

    // R5: mask word with byte enables
    wr(6'h0C, 32'hA5A5_0F0F, 4'b0101);
    chk("R5 req mask", req_now(), 64'h00A5_000F);
    rd(6'h0C, d); chk("R5 req read", 64'(d), 64'h00A5_000F);
    wr(6'h14, 32'h1234_5678, 4'b1000);
    rd(6'h14, d); chk("R5 eei read", 64'(d), 64'h1200_0000);
    wr(6'h14, 32'h0, 4'hF);
    wr(6'h0C, 32'h0, 4'hF);

    // R12: control word
    wr(6'h00, 32'hDEAD_BEEF, 4'b0110);
    rd(6'h00, d); chk("R12 ctrl", 64'(d), 64'h00AD_BE00);

    // R6 / R7: flags and outputs
    pulse(1, 64'h80);
    chk("R7 err masked", {63'h0, eirq_now()}, 64'h0);
    rd(6'h2C, d); chk("R6 err word", 64'(d), 64'h80);
    rd(6'h04, d); chk("R6 estat", 64'(d), 64'h8000_0007);
    pulse(1, 64'h04);
    rd(6'h04, d); chk("R6 estat lowest", 64'(d), 64'h8000_0002);
    wrb(6'h19, 8'd7);
    chk("R7 err enabled", {63'h0, eirq_now()}, 64'h1);
    pulse(0, 64'h200);
    chk("R7 irq", {63'h0, irq_now()}, 64'h1);
    rd(6'h24, d); chk("R6 int word", 64'(d), 64'h200);

    // R10: flag and status words ignore writes
    wr(6'h24, 32'hFFFF_FFFF, 4'hF);
    wr(6'h2C, 32'h0, 4'hF);
    wr(6'h04, 32'h0, 4'hF);
    rd(6'h24, d); chk("R10 int unchanged", 64'(d), 64'h200);
    rd(6'h2C, d); chk("R10 err unchanged", 64'(d), 64'h84);
    rd(6'h04, d); chk("R10 estat unchanged", 64'(d), 64'h8000_0002);

    // R2 clears of flags
    wrb(6'h1F, 8'd9);
    chk("R2 clr int", {63'h0, irq_now()}, 64'h0);
    wrb(6'h1E, 8'd7);
    chk("R2 clr err", {63'h0, eirq_now()}, 64'h0);
    wrb(6'h1E, 8'd2);
    rd(6'h2C, d); chk("R2 err cleared", 64'(d), 64'h0);

    // R8: hardware set and software clear in the same cycle
    @(negedge clk);
    int_set = 64'h10; wr_en = 1'b1; wr_addr = 6'h1C; wr_be = 4'b1000; wr_data = 32'h0400_0000;
    @(negedge clk);
    int_set = '0; wr_en = 1'b0; wr_be = '0;
    chk("R8 int set wins irq", {63'h0, irq_now()}, 64'h1);
    rd(6'h24, d); chk("R8 int set wins", 64'(d), 64'h10);
    @(negedge clk);
    done_set = 64'h8; wr_en = 1'b1; wr_addr = 6'h1C; wr_be = 4'b0001; wr_data = 32'h0000_0003;
    @(negedge clk);
    done_set = '0; wr_en = 1'b0; wr_be = '0;
    chk("R8 done set wins", done_now(), 64'h8);

    // R9: done clear, start set/ack
    wrb(6'h1C, 8'd3);
    chk("R9 done clr", done_now(), 64'h0);
    @(negedge clk);
    start_ack = 64'h1000; wr_en = 1'b1; wr_addr = 6'h1D; wr_be = 4'b0010; wr_data = 32'h0000_0C00;
    @(negedge clk);
    start_ack = '0; wr_en = 1'b0; wr_be = '0;
    chk("R8 start set wins", start_now(), 64'h1000);
    pulse(3, 64'h1000);
    chk("R9 start ack", start_now(), 64'h0);

    // R11: wide layout
    sel = 1'b1;
    exp = 0;
    for (int c = 0; c < 64; c++) begin
      wrb(6'h18, 8'(c)); exp[c] = 1'b1;
      chk("R11 wide set req", req_now(), exp);
    end
    rd(6'h08, d); chk("R11 req hi", 64'(d), 64'hFFFF_FFFF);
    for (int c = 0; c < 64; c += 3) begin
      wrb(6'h19, 8'(c)); exp[c] = 1'b0;
      chk("R11 wide clr req", req_now(), exp);
    end
    rd(6'h0C, d); chk("R11 req lo", 64'(d), 64'(exp[31:0]));
    wrb(6'h1A, 8'd40);
    rd(6'h10, d); chk("R11 eei hi", 64'(d), 64'h100);
    pulse(1, 64'h0000_0100_0000_0000);
    chk("R11 wide err irq", {63'h0, eirq_now()}, 64'h1);
    rd(6'h28, d); chk("R11 err hi", 64'(d), 64'h100);
    wrb(6'h1B, 8'd40);
    chk("R11 clr eei", {63'h0, eirq_now()}, 64'h0);
    wrb(6'h1D, 8'd40);
    rd(6'h28, d); chk("R11 clr err", 64'(d), 64'h0);
    pulse(0, 64'h8000_0000_0000_0000);
    rd(6'h20, d); chk("R11 int hi", 64'(d), 64'h8000_0000);
    wrb(6'h1C, 8'd63);
    chk("R11 clr int", {63'h0, irq_now()}, 64'h0);
    wrb(6'h1E, 8'd50);
    chk("R11 set start", start_now(), 64'h0004_0000_0000_0000);
    pulse(2, 64'h0000_0002_0000_0000);
    wrb(6'h1F, 8'd33);
    chk("R11 clr done", done_now(), 64'h0);
    wrb(6'h18, 8'hC0);
    chk("R3 wide all", req_now(), 64'hFFFF_FFFF_FFFF_FFFF);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule